// File: doc/BRIEF.md
# Warp Issue Scheduler with Deferred Spawn

This block holds the scheduling state of one SIMT core that runs a parameterised number of warps. For every warp it keeps an active bit, a stall bit, a thread mask and a program counter. Each cycle it names the warp that may issue: the lowest-numbered warp that is active and not stalled. Alongside that warp ID it drives a valid flag and the warp's PC and thread mask. After reset only warp 0 runs, with a single thread enabled, and every PC holds the value on the startup-address input.

Software widens execution with a spawn request. The request carries a warp count and a target PC. When it cannot take effect at once, the block records it as a pending spawn and releases it on the first cycle in which exactly one warp is active. It then wakes warps 1 to count-1 at the target PC, each with only thread 0 enabled. The pending record is examined before the issue choice in the same cycle.

Suspend and resume commands stall and release warps by ID, and one reserved ID releases all of them. An illegal command raises an error flag for one cycle. A stop command clears every active bit.

Top module: `warp_sched`

## Requirements
- R1: While reset is held, and on the first cycle after it, only warp 0 is active. Warp 0's thread mask is 1 (bit 0 only). No stall bit is set, no spawn is pending, and every warp PC equals `start_pc_i`.
- R2: A spawn request's count is clamped to NUM_WARPS. If the clamped count is below 2 and exactly one warp is active, the request finishes at once. Nothing is recorded, so a later cycle does not clear warp 0's stall bit.
- R3: Every other spawn request replaces the pending record. The record is applied only when exactly one warp is active. Warps 1 to count-1 then become active, take the target PC and thread mask 1. The record is dropped and warp 0's stall bit is cleared.
- R4: The pending record is applied before the issue choice in the same cycle. In the first cycle after a request is recorded while one warp is active, `active_mask_o` and the issue outputs already show the spawned warps.
- R5: `issue_valid_o` is 1 exactly when some warp is active and not stalled. `issue_wid_o` is then the lowest such index.
- R6: A suspend sets the named warp's stall bit. A resume clears it. A resume with ID all-ones (`{ID_W{1'b1}}`, ID_W = WID_W+1) clears every stall bit. Suspend is applied before resume in the same cycle.
- R7: `err_o` is 1 in the cycle after an illegal command, and the named warp's state is left unchanged. Illegal commands are: a suspend of a stalled warp, a suspend with an ID of NUM_WARPS or more, or a resume of a warp that is not stalled or whose ID is out of range (other than all-ones).
- R8: `stop_i` clears every active bit from the next cycle on. `running_o` is 1 exactly when any warp is active.
- R9: `issue_pc_o` and `issue_tmask_o` carry the PC and thread mask of the warp named by `issue_wid_o`, and are 0 when nothing issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pc_i | input | PC_W | PC loaded into every warp at reset |
| susp_v_i | input | 1 | Suspend command valid |
| susp_id_i | input | ID_W | Warp to suspend |
| resm_v_i | input | 1 | Resume command valid |
| resm_id_i | input | ID_W | Warp to resume; all-ones releases every warp |
| spawn_v_i | input | 1 | Spawn request valid |
| spawn_cnt_i | input | CNT_W | Requested warp count |
| spawn_pc_i | input | PC_W | Start PC for spawned warps |
| stop_i | input | 1 | Deactivate all warps |
| issue_valid_o | output | 1 | A warp issues this cycle |
| issue_wid_o | output | WID_W | Issuing warp |
| issue_pc_o | output | PC_W | PC of the issuing warp |
| issue_tmask_o | output | NUM_THREADS | Thread mask of the issuing warp |
| active_mask_o | output | NUM_WARPS | Active bit per warp |
| stall_mask_o | output | NUM_WARPS | Stall bit per warp |
| running_o | output | 1 | Any warp active |
| err_o | output | 1 | Previous cycle held an illegal command |

## Verification
The hardest case to reach from the ports is a recorded spawn that must wait. Only reset or an immediate apply brings the core back to a single active warp, so the deferred record is seen mostly as a spawn that never takes effect. Directed sequences first wake all warps and then issue a second spawn with a new PC. They suspend lower warps to show that the PCs of the higher warps stay put. Random phases, each opened by a reset with a fresh startup PC, mix suspend, resume, broadcast resume, clamped spawns and rare stops. A bench model that applies the deferred spawn before choosing the issuing warp is compared with the outputs every cycle.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
package ws_pkg;
    localparam int WS_DEF_WARPS   = 8;
    localparam int WS_DEF_THREADS = 4;
    localparam int WS_DEF_PC_W    = 32;
    localparam int WS_DEF_CNT_W   = 8;
endpackage

// File: rtl/ws_single_hot.sv
`timescale 1ns/1ps
module ws_single_hot #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec_i,
    output logic         one_o
);
    always_comb begin
        one_o = (vec_i != '0) && ((vec_i & (vec_i - W'(1))) == '0);
    end
endmodule

// File: rtl/ws_low_pick.sv
`timescale 1ns/1ps
module ws_low_pick #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  req_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ws_spawn_fill.sv
`timescale 1ns/1ps
module ws_spawn_fill #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic          en_i,
    input  logic [CW-1:0] cnt_i,
    output logic [W-1:0]  fill_o
);
    assign fill_o[0] = 1'b0;
    for (genvar g = 1; g < W; g++) begin : g_fill
        assign fill_o[g] = en_i && (cnt_i > CW'(g));
    end
endmodule

// File: rtl/warp_sched.sv
`timescale 1ns/1ps
module warp_sched
    import ws_pkg::*;
#(
    parameter int NUM_WARPS   = WS_DEF_WARPS,
    parameter int NUM_THREADS = WS_DEF_THREADS,
    parameter int PC_W        = WS_DEF_PC_W,
    parameter int CNT_W       = WS_DEF_CNT_W,
    localparam int WID_W      = $clog2(NUM_WARPS),
    localparam int ID_W       = WID_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PC_W-1:0]        start_pc_i,
    input  logic                   susp_v_i,
    input  logic [ID_W-1:0]        susp_id_i,
    input  logic                   resm_v_i,
    input  logic [ID_W-1:0]        resm_id_i,
    input  logic                   spawn_v_i,
    input  logic [CNT_W-1:0]       spawn_cnt_i,
    input  logic [PC_W-1:0]        spawn_pc_i,
    input  logic                   stop_i,
    output logic                   issue_valid_o,
    output logic [WID_W-1:0]       issue_wid_o,
    output logic [PC_W-1:0]        issue_pc_o,
    output logic [NUM_THREADS-1:0] issue_tmask_o,
    output logic [NUM_WARPS-1:0]   active_mask_o,
    output logic [NUM_WARPS-1:0]   stall_mask_o,
    output logic                   running_o,
    output logic                   err_o
);
    localparam int CW = $clog2(NUM_WARPS + 1);
    localparam logic [ID_W-1:0] ID_ALL = {ID_W{1'b1}};

    typedef struct packed {
        logic [NUM_WARPS-1:0]                  act;
        logic [NUM_WARPS-1:0]                  stl;
        logic [NUM_WARPS-1:0][NUM_THREADS-1:0] tm;
        logic [NUM_WARPS-1:0][PC_W-1:0]        pc;
        logic                                  pend;
        logic [CW-1:0]                         pcnt;
        logic [PC_W-1:0]                       ppc;
        logic                                  err;
    } sched_t;

    sched_t st_q, st_d, eff_s, rst_s;

    logic                 one_q, one_eff, apply_s, pick_v;
    logic [NUM_WARPS-1:0] fill_s;
    logic [WID_W-1:0]     pick_idx;
    logic [CW-1:0]        clamp_cnt;

    // exactly one warp active in registered state: pending spawn may apply
    ws_single_hot #(.W(NUM_WARPS)) u_one_q (.vec_i(st_q.act), .one_o(one_q));

    assign apply_s = st_q.pend && one_q;

    ws_spawn_fill #(.W(NUM_WARPS), .CW(CW)) u_fill (
        .en_i  (apply_s),
        .cnt_i (st_q.pcnt),
        .fill_o(fill_s)
    );

    // stage 1: state seen by this cycle's selection (pending spawn applied)
    always_comb begin
        eff_s = st_q;
        for (int i = 0; i < NUM_WARPS; i++) begin
            if (fill_s[i]) begin
                eff_s.act[i] = 1'b1;
                eff_s.tm[i]  = NUM_THREADS'(1);
                eff_s.pc[i]  = st_q.ppc;
            end
        end
        if (apply_s) begin
            eff_s.pend   = 1'b0;
            eff_s.stl[0] = 1'b0;
        end
    end

    ws_single_hot #(.W(NUM_WARPS)) u_one_eff (.vec_i(eff_s.act), .one_o(one_eff));

    ws_low_pick #(.W(NUM_WARPS), .IW(WID_W)) u_pick (
        .req_i  (eff_s.act & ~eff_s.stl),
        .valid_o(pick_v),
        .idx_o  (pick_idx)
    );

    always_comb begin
        if (spawn_cnt_i > CNT_W'(NUM_WARPS)) begin
            clamp_cnt = CW'(NUM_WARPS);
        end else begin
            clamp_cnt = CW'(spawn_cnt_i);
        end
    end

    // stage 2: commands on top of the effective state
    always_comb begin
        st_d     = eff_s;
        st_d.err = 1'b0;
        if (susp_v_i) begin
            if ((susp_id_i >= ID_W'(NUM_WARPS)) || st_d.stl[susp_id_i[WID_W-1:0]]) begin
                st_d.err = 1'b1;
            end else begin
                st_d.stl[susp_id_i[WID_W-1:0]] = 1'b1;
            end
        end
        if (resm_v_i) begin
            if (resm_id_i == ID_ALL) begin
                st_d.stl = '0;
            end else if ((resm_id_i >= ID_W'(NUM_WARPS)) ||
                         !st_d.stl[resm_id_i[WID_W-1:0]]) begin
                st_d.err = 1'b1;
            end else begin
                st_d.stl[resm_id_i[WID_W-1:0]] = 1'b0;
            end
        end
        if (spawn_v_i && !((clamp_cnt < CW'(2)) && one_eff)) begin
            st_d.pend = 1'b1;
            st_d.pcnt = clamp_cnt;
            st_d.ppc  = spawn_pc_i;
        end
        if (stop_i) begin
            st_d.act = '0;
        end
    end

    always_comb begin
        rst_s       = '0;
        rst_s.act   = NUM_WARPS'(1);
        rst_s.tm[0] = NUM_THREADS'(1);
        for (int i = 0; i < NUM_WARPS; i++) begin
            rst_s.pc[i] = start_pc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= rst_s;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        issue_valid_o = pick_v;
        issue_wid_o   = pick_idx;
        issue_pc_o    = pick_v ? eff_s.pc[pick_idx] : '0;
        issue_tmask_o = pick_v ? eff_s.tm[pick_idx] : '0;
        active_mask_o = eff_s.act;
        stall_mask_o  = eff_s.stl;
        running_o     = |eff_s.act;
        err_o         = st_q.err;
    end
endmodule

// File: rtl/ws_sched_chk.sv
`timescale 1ns/1ps
module ws_sched_chk #(
    parameter int NUM_WARPS   = 8,
    parameter int NUM_THREADS = 4,
    parameter int WID_W       = 3,
    parameter int ID_W        = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   susp_v_i,
    input logic [ID_W-1:0]        susp_id_i,
    input logic                   resm_v_i,
    input logic [ID_W-1:0]        resm_id_i,
    input logic                   stop_i,
    input logic                   issue_valid_o,
    input logic [WID_W-1:0]       issue_wid_o,
    input logic [NUM_THREADS-1:0] issue_tmask_o,
    input logic [NUM_WARPS-1:0]   active_mask_o,
    input logic [NUM_WARPS-1:0]   stall_mask_o,
    input logic                   running_o,
    input logic                   err_o
);
    logic [NUM_WARPS-1:0] ready_w;
    logic [NUM_WARPS-1:0] below_w;
    assign ready_w = active_mask_o & ~stall_mask_o;
    assign below_w = (NUM_WARPS'(1) << issue_wid_o) - NUM_WARPS'(1);

    AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> ready_w[issue_wid_o]);                          // R5
    AST_ISSUE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> ((ready_w & below_w) == '0));                   // R5
    AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid_o |-> (ready_w == '0));                              // R5
    AST_SUSP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_v_i && susp_id_i != '0 && susp_id_i < ID_W'(NUM_WARPS) && !resm_v_i)
        |=> stall_mask_o[$past(susp_id_i[WID_W-1:0])]);                   // R6
    AST_RESUME_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (resm_v_i && resm_id_i == {ID_W{1'b1}}) |=> (stall_mask_o == '0)); // R6
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(susp_v_i || resm_v_i));                           // R7
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (active_mask_o == '0));                                // R8
    AST_RUN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> $past(stop_i));                              // R8
    AST_TMASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> (issue_tmask_o != '0));                         // R9
endmodule

bind warp_sched ws_sched_chk #(
    .NUM_WARPS  (NUM_WARPS),
    .NUM_THREADS(NUM_THREADS),
    .WID_W      (WID_W),
    .ID_W       (ID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .susp_v_i     (susp_v_i),
    .susp_id_i    (susp_id_i),
    .resm_v_i     (resm_v_i),
    .resm_id_i    (resm_id_i),
    .stop_i       (stop_i),
    .issue_valid_o(issue_valid_o),
    .issue_wid_o  (issue_wid_o),
    .issue_tmask_o(issue_tmask_o),
    .active_mask_o(active_mask_o),
    .stall_mask_o (stall_mask_o),
    .running_o    (running_o),
    .err_o        (err_o)
);

// File: tb/warp_sched_tb.sv
`timescale 1ns/1ps
module warp_sched_tb;
    localparam int N  = 8;
    localparam int T  = 4;
    localparam int PW = 32;
    localparam int CNW = 8;
    localparam int WW = 3;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PW-1:0] start_pc = 32'h1000;
    logic sus_v = 0, res_v = 0, spn_v = 0, stp = 0;
    logic [IW-1:0] sus_id = '0, res_id = '0;
    logic [CNW-1:0] spn_cnt = '0;
    logic [PW-1:0] spn_pc = '0;

    logic iv, run, err;
    logic [WW-1:0] iw;
    logic [PW-1:0] ipc;
    logic [T-1:0] itm;
    logic [N-1:0] am, sm;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    warp_sched u_dut (
        .clk(clk), .rst_n(rst_n), .start_pc_i(start_pc),
        .susp_v_i(sus_v), .susp_id_i(sus_id), .resm_v_i(res_v), .resm_id_i(res_id),
        .spawn_v_i(spn_v), .spawn_cnt_i(spn_cnt), .spawn_pc_i(spn_pc), .stop_i(stp),
        .issue_valid_o(iv), .issue_wid_o(iw), .issue_pc_o(ipc), .issue_tmask_o(itm),
        .active_mask_o(am), .stall_mask_o(sm), .running_o(run), .err_o(err)
    );

    // reference model
    logic [N-1:0] m_act, m_stl, e_act, e_stl;
    logic [PW-1:0] m_pc [N];
    logic [PW-1:0] e_pc [N];
    logic [T-1:0] m_tm [N];
    logic [T-1:0] e_tm [N];
    bit m_pend, e_pend, m_err;
    int m_pcnt;
    logic [PW-1:0] m_ppc;

    task automatic model_reset(input logic [PW-1:0] pc);
        m_act = N'(1); m_stl = '0; m_pend = 0; m_pcnt = 0; m_ppc = '0; m_err = 0;
        for (int i = 0; i < N; i++) begin
            m_pc[i] = pc; m_tm[i] = (i == 0) ? T'(1) : '0;
        end
    endtask

    task automatic model_eff();
        e_act = m_act; e_stl = m_stl; e_pend = m_pend;
        for (int i = 0; i < N; i++) begin e_pc[i] = m_pc[i]; e_tm[i] = m_tm[i]; end
        if (m_pend && $countones(m_act) == 1) begin
            for (int i = 1; i < m_pcnt; i++) begin
                e_act[i] = 1'b1; e_pc[i] = m_ppc; e_tm[i] = T'(1);
            end
            e_pend = 0; e_stl[0] = 1'b0;
        end
    endtask

    task automatic model_step();
        int c;
        model_eff();
        m_act = e_act; m_stl = e_stl; m_pend = e_pend;
        for (int i = 0; i < N; i++) begin m_pc[i] = e_pc[i]; m_tm[i] = e_tm[i]; end
        m_err = 0;
        if (sus_v) begin
            if (int'(sus_id) >= N || m_stl[sus_id[WW-1:0]]) m_err = 1;
            else m_stl[sus_id[WW-1:0]] = 1'b1;
        end
        if (res_v) begin
            if (res_id == '1) m_stl = '0;
            else if (int'(res_id) >= N || !m_stl[res_id[WW-1:0]]) m_err = 1;
            else m_stl[res_id[WW-1:0]] = 1'b0;
        end
        if (spn_v) begin
            c = (int'(spn_cnt) > N) ? N : int'(spn_cnt);
            if (!(c < 2 && $countones(m_act) == 1)) begin
                m_pend = 1; m_pcnt = c; m_ppc = spn_pc;
            end
        end
        if (stp) m_act = '0;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic ev;
        int ew;
        model_eff();
        ev = 0; ew = 0;
        for (int i = N - 1; i >= 0; i--) if (e_act[i] && !e_stl[i]) begin ev = 1; ew = i; end
        chk("R5 issue_valid", 64'(iv), 64'(ev));
        if (ev) begin
            chk("R5 issue_wid", 64'(iw), 64'(ew));
            chk("R9 issue_pc", 64'(ipc), 64'(e_pc[ew]));
            chk("R9 issue_tmask", 64'(itm), 64'(e_tm[ew]));
        end else begin
            chk("R9 idle pc", 64'(ipc), 64'd0);
        end
        chk("R3 active_mask", 64'(am), 64'(e_act));
        chk("R6 stall_mask", 64'(sm), 64'(e_stl));
        chk("R7 err", 64'(err), 64'(m_err));
        chk("R8 running", 64'(run), 64'(e_act != '0));
    endtask

    task automatic clear_in();
        sus_v = 0; res_v = 0; spn_v = 0; stp = 0;
        sus_id = '0; res_id = '0; spn_cnt = '0; spn_pc = '0;
    endtask

    // inputs already driven after a negedge; advance one cycle and compare
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        clear_in();
        compare_all();
    endtask

    task automatic do_reset(input logic [PW-1:0] pc);
        @(negedge clk);
        rst_n = 0; start_pc = pc; clear_in();
        repeat (3) @(negedge clk);
        model_reset(pc);
        rst_n = 1;
        compare_all();
    endtask

    task automatic sus(input int id);  sus_v = 1; sus_id = IW'(id); endtask
    task automatic res(input int id);  res_v = 1; res_id = IW'(id); endtask
    task automatic spawn(input int c, input logic [PW-1:0] pc);
        spn_v = 1; spn_cnt = CNW'(c); spn_pc = pc;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_in();
        do_reset(32'h1000);
        // R1: reset state
        chk("R1 active", 64'(am), 64'h01);
        chk("R1 stall", 64'(sm), 64'h00);
        chk("R1 wid", 64'(iw), 64'd0);
        chk("R1 pc", 64'(ipc), 64'h1000);
        chk("R1 tmask", 64'(itm), 64'h1);

        // R2: count 1 with a single active warp completes at once
        sus(0); step();
        chk("R2 stalled w0", 64'(sm), 64'h01);
        spawn(1, 32'h2000); step();
        step(); step();
        chk("R2 no pending, stall kept", 64'(sm), 64'h01);
        chk("R2 no issue", 64'(iv), 64'd0);

        // R2 clamp + R4 same-cycle apply
        do_reset(32'h1100);
        spawn(200, 32'h3000); step();
        chk("R4 spawned visible", 64'(am), 64'hFF);
        chk("R4 issue w0", 64'(iw), 64'd0);
        sus(0); step();
        chk("R3 w1 pc", 64'(ipc), 64'h3000);
        chk("R3 w1 tmask", 64'(itm), 64'h1);
        chk("R3 w1 wid", 64'(iw), 64'd1);

        // R3 deferred: many active, new spawn must not move PCs
        spawn(3, 32'h4000); step();
        repeat (5) step();
        sus(1); step();
        chk("R3 w2 pc unchanged", 64'(ipc), 64'h3000);
        chk("R3 stall not cleared", 64'(sm), 64'h03);

        // R7: illegal commands
        sus(1); step();
        chk("R7 double suspend", 64'(err), 64'd1);
        chk("R7 stall unchanged", 64'(sm), 64'h03);
        res(5); step();
        chk("R7 resume idle", 64'(err), 64'd1);
        sus(9); step();
        chk("R7 range", 64'(err), 64'd1);
        // R6: broadcast resume
        sus(4); res(15); step();
        chk("R6 resume all", 64'(sm), 64'h00);
        chk("R6 issue w0", 64'(iw), 64'd0);
        // R8: stop
        stp = 1; step();
        chk("R8 running", 64'(run), 64'd0);
        chk("R8 no issue", 64'(iv), 64'd0);

        // random phases
        for (int ph = 0; ph < 10; ph++) begin
            do_reset($urandom());
            for (int k = 0; k < 400; k++) begin
                if ($urandom_range(99) < 25) sus($urandom_range(N));
                if ($urandom_range(99) < 25) res(($urandom_range(9) == 0) ? 15 : $urandom_range(N));
                if ($urandom_range(99) < 6) spawn($urandom_range(11), $urandom());
                if ($urandom_range(999) < 3) stp = 1;
                step();
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule